// File: doc/BRIEF.md
# Dual-Mode Split-Lane Line Buffer

This block is a line or field buffer built from two 16-bit storage lanes, each with its own write pointer and read pointer. Words are written on a write clock and read back in order on a read clock. A static mode input chooses how the lanes are used. In wide mode they act as one 32-bit FIFO, run only from the port-0 clocks and controls. In split mode they act as two independent 16-bit FIFOs, each with its own clocks and controls.

Each side has a synchronous pointer reset, and the two resets act independently. After a read reset the buffer contents can be read again from address 0. If a reset arrives while its side is disabled, it is held and carried out on the next enabled cycle of that side. A static polarity input sets the active level of all six control inputs together. The output stage is registered and is qualified by a valid flag in place of a tri-state driver.

Top module: `dualmode_line_fifo`

## Requirements
- R1: With `pol_low` = 0 all six controls (write enable, input enable, write reset, read enable, output enable, read reset) are active high. With `pol_low` = 1 all six are active low, and a high level on any of them has no effect.
- R2: A word is stored at the write pointer, and the pointer advances by one, only on a write-clock edge where write enable and input enable are both active. If write enable is active and input enable is inactive, nothing is stored and the pointer holds.
- R3: On each read-clock edge where read enable is active, the word at the read pointer is loaded into the output register and the read pointer advances by one. The output register holds its value on every other edge.
- R4: Each pointer wraps from DEPTH-1 to 0. A buffer filled past its end overwrites from address 0.
- R5: A reset on an enabled cycle of its side sets that side's pointer to 0. That cycle performs no store (write side) or load (read side).
- R6: A reset on a cycle where its side's enable is inactive is recorded as pending. It is carried out on that side's next enabled cycle, which then performs no store or load.
- R7: The write and read resets are independent. A read reset alone makes the next reads return the words from address 0 onward again.
- R8: On each read-clock edge the valid output takes the output-enable level of that edge. While valid is low the data output reads 0. While valid is high the data output shows the output register.
- R9: With `mode_split` = 0 the block is one FIFO whose write word is {`wr_data_p1`, `wr_data_p0`} and whose read word is {`rd_data_p1`, `rd_data_p0`}. Both lanes use only the port-0 clocks and controls, and all port-1 clocks and controls are ignored. Both valid outputs follow port-0 output enable.
- R10: With `mode_split` = 1 each lane is a separate 16-bit FIFO on its own port's clocks and controls. Activity on one port does not change the other port's pointers or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_split | input | 1 | 0: one 32-bit FIFO, 1: two 16-bit FIFOs (static) |
| pol_low | input | 1 | 1: controls active low, 0: active high (static) |
| wr_clk_p0 | input | 1 | Write clock, port 0 |
| wr_rst_p0 | input | 1 | Write pointer reset, port 0 |
| wr_en_p0 | input | 1 | Write enable, port 0 |
| wr_in_en_p0 | input | 1 | Input enable, port 0 |
| wr_data_p0 | input | LANE_W | Write data, lane 0 |
| rd_clk_p0 | input | 1 | Read clock, port 0 |
| rd_rst_p0 | input | 1 | Read pointer reset, port 0 |
| rd_en_p0 | input | 1 | Read enable, port 0 |
| rd_out_en_p0 | input | 1 | Output enable, port 0 |
| rd_data_p0 | output | LANE_W | Read data, lane 0 |
| rd_valid_p0 | output | 1 | Read data qualifier, lane 0 |
| wr_clk_p1 | input | 1 | Write clock, port 1 |
| wr_rst_p1 | input | 1 | Write pointer reset, port 1 |
| wr_en_p1 | input | 1 | Write enable, port 1 |
| wr_in_en_p1 | input | 1 | Input enable, port 1 |
| wr_data_p1 | input | LANE_W | Write data, lane 1 |
| rd_clk_p1 | input | 1 | Read clock, port 1 |
| rd_rst_p1 | input | 1 | Read pointer reset, port 1 |
| rd_en_p1 | input | 1 | Read enable, port 1 |
| rd_out_en_p1 | input | 1 | Output enable, port 1 |
| rd_data_p1 | output | LANE_W | Read data, lane 1 |
| rd_valid_p1 | output | 1 | Read data qualifier, lane 1 |

## Verification
Once a side has executed its first reset, the assertions check on every edge that the pointer steps, holds, wraps and clears as its decoded enables and resets dictate. They also check that a disabled-cycle reset leaves a pending mark that the next enabled cycle consumes, that a store lands at the pointer it was issued against, and that the output register and valid flag track the read controls. Some behaviour only the bench's scenarios can show, because it spans the ports and the data path. This covers the decoding of the polarity select at the pins, the ordering of words through a wrap, the re-read after a lone read reset, and the way wide mode concatenates lanes while ignoring every port-1 input. It also covers the separation of the two lanes in split mode under unrelated clocks.

// File: rtl/dlf_pkg.sv
`timescale 1ns/1ps
package dlf_pkg;

   // Decoded (active-high) controls of one side of one port.
   // Bit order en, gate, rst matches the packing used at the top level.
   typedef struct packed {
      logic en;    // side enable (write enable / read enable)
      logic gate;  // input enable (write) / output enable (read)
      logic rst;   // pointer reset request
   } side_ctl_t;

   localparam int NUM_LANES = 2;
   localparam int CTL_PER_PORT = 6;

endpackage

// File: rtl/dlf_pol_norm.sv
`timescale 1ns/1ps
module dlf_pol_norm #(
   parameter int N = 12
) (
   input  logic [N-1:0] raw_i,
   input  logic         pol_low_i,
   output logic [N-1:0] act_o
);

   if (N < 1) begin : g_bad_n
      $error("dlf_pol_norm: N must be at least 1");
   end

   // One shared polarity for every control line.
   for (genvar i = 0; i < N; i++) begin : g_bit
      assign act_o[i] = raw_i[i] ^ pol_low_i;
   end

endmodule

// File: rtl/dlf_ptr_ctl.sv
`timescale 1ns/1ps
module dlf_ptr_ctl #(
   parameter int DEPTH = 64,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          en_i,
   input  logic          go_i,
   input  logic          rst_i,
   output logic [AW-1:0] ptr_o,
   output logic          fire_o,
   output logic          armed_o
);

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("dlf_ptr_ctl: DEPTH must be at least 2");
   end

   logic [AW-1:0] ptr_q   = '0;
   logic          pend_q  = 1'b0;
   logic          armed_q = 1'b0;
   logic          clear_now;

   // A held or fresh reset replaces the access of an enabled cycle.
   assign clear_now = en_i & (rst_i | pend_q);
   assign fire_o    = en_i & go_i & ~rst_i & ~pend_q;
   assign ptr_o     = ptr_q;
   assign armed_o   = armed_q;

   always_ff @(posedge clk) begin
      if (clear_now) begin
         ptr_q   <= '0;
         pend_q  <= 1'b0;
         armed_q <= 1'b1;
      end else if (fire_o) begin
         ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      end else if (!en_i && rst_i) begin
         pend_q <= 1'b1;
      end
   end

   a_r5_reset_clears: assert property (@(posedge clk) disable iff (!armed_q)
      (en_i && rst_i) |=> (ptr_q == '0))
      else $error("a_r5_reset_clears");

   a_r6_pending_kept: assert property (@(posedge clk) disable iff (!armed_q)
      (!en_i && rst_i) |=> pend_q)
      else $error("a_r6_pending_kept");

   a_r6_pending_used: assert property (@(posedge clk) disable iff (!armed_q)
      (en_i && pend_q) |=> (!pend_q && ptr_q == '0))
      else $error("a_r6_pending_used");

   a_r2_idle_holds: assert property (@(posedge clk) disable iff (!armed_q)
      (!en_i || (!go_i && !rst_i && !pend_q)) |=> $stable(ptr_q))
      else $error("a_r2_idle_holds");

   a_r4_step_wrap: assert property (@(posedge clk) disable iff (!armed_q)
      fire_o |=> (($past(ptr_q) == LAST) ? (ptr_q == '0) : (ptr_q == $past(ptr_q) + 1'b1)))
      else $error("a_r4_step_wrap");

endmodule

// File: rtl/dlf_lane.sv
`timescale 1ns/1ps
module dlf_lane
   import dlf_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int LANE_W = 16,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              wclk,
   input  logic              rclk,
   input  side_ctl_t         wc,
   input  side_ctl_t         rc,
   input  logic [LANE_W-1:0] din,
   output logic [LANE_W-1:0] dout,
   output logic              dval
);

   if (LANE_W < 1) begin : g_bad_width
      $error("dlf_lane: LANE_W must be at least 1");
   end

   logic [AW-1:0]     w_ptr, r_ptr;
   logic              w_fire, r_fire, w_armed, r_armed;
   logic [LANE_W-1:0] mem [DEPTH];
   logic [LANE_W-1:0] word_q = '0;
   logic              val_q  = 1'b0;

   dlf_ptr_ctl #(.DEPTH(DEPTH)) u_wptr (
      .clk    (wclk),
      .en_i   (wc.en),
      .go_i   (wc.gate),
      .rst_i  (wc.rst),
      .ptr_o  (w_ptr),
      .fire_o (w_fire),
      .armed_o(w_armed)
   );

   dlf_ptr_ctl #(.DEPTH(DEPTH)) u_rptr (
      .clk    (rclk),
      .en_i   (rc.en),
      .go_i   (1'b1),
      .rst_i  (rc.rst),
      .ptr_o  (r_ptr),
      .fire_o (r_fire),
      .armed_o(r_armed)
   );

   always_ff @(posedge wclk) begin
      if (w_fire) mem[w_ptr] <= din;
   end

   // Registered output; output enable becomes the qualifier.
   always_ff @(posedge rclk) begin
      if (r_fire) word_q <= mem[r_ptr];
      val_q <= rc.gate;
   end

   assign dout = {LANE_W{val_q}} & word_q;
   assign dval = val_q;

   a_r2_store_lands: assert property (@(posedge wclk) disable iff (!w_armed)
      w_fire |=> (mem[$past(w_ptr)] == $past(din)))
      else $error("a_r2_store_lands");

   a_r3_word_holds: assert property (@(posedge rclk) disable iff (!r_armed)
      !r_fire |=> $stable(word_q))
      else $error("a_r3_word_holds");

   a_r8_valid_tracks: assert property (@(posedge rclk)
      rc.gate |=> dval)
      else $error("a_r8_valid_tracks");

endmodule

// File: rtl/dualmode_line_fifo.sv
`timescale 1ns/1ps
module dualmode_line_fifo
   import dlf_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int LANE_W = 16
) (
   input  logic              mode_split,
   input  logic              pol_low,
   input  logic              wr_clk_p0,
   input  logic              wr_rst_p0,
   input  logic              wr_en_p0,
   input  logic              wr_in_en_p0,
   input  logic [LANE_W-1:0] wr_data_p0,
   input  logic              rd_clk_p0,
   input  logic              rd_rst_p0,
   input  logic              rd_en_p0,
   input  logic              rd_out_en_p0,
   output logic [LANE_W-1:0] rd_data_p0,
   output logic              rd_valid_p0,
   input  logic              wr_clk_p1,
   input  logic              wr_rst_p1,
   input  logic              wr_en_p1,
   input  logic              wr_in_en_p1,
   input  logic [LANE_W-1:0] wr_data_p1,
   input  logic              rd_clk_p1,
   input  logic              rd_rst_p1,
   input  logic              rd_en_p1,
   input  logic              rd_out_en_p1,
   output logic [LANE_W-1:0] rd_data_p1,
   output logic              rd_valid_p1
);

   localparam int N_CTL = NUM_LANES * CTL_PER_PORT;

   if (DEPTH < 2) begin : g_bad_depth
      $error("dualmode_line_fifo: DEPTH must be at least 2");
   end

   logic [N_CTL-1:0] raw_ctl, act_ctl;

   // Per port, from high to low: wr_en, wr_in_en, wr_rst, rd_en, rd_out_en, rd_rst.
   assign raw_ctl = {wr_en_p1, wr_in_en_p1, wr_rst_p1, rd_en_p1, rd_out_en_p1, rd_rst_p1,
                     wr_en_p0, wr_in_en_p0, wr_rst_p0, rd_en_p0, rd_out_en_p0, rd_rst_p0};

   dlf_pol_norm #(.N(N_CTL)) u_pol (
      .raw_i    (raw_ctl),
      .pol_low_i(pol_low),
      .act_o    (act_ctl)
   );

   side_ctl_t         port_w   [NUM_LANES];
   side_ctl_t         port_r   [NUM_LANES];
   logic              port_wck [NUM_LANES];
   logic              port_rck [NUM_LANES];
   logic [LANE_W-1:0] port_din [NUM_LANES];
   logic [LANE_W-1:0] lane_do  [NUM_LANES];
   logic              lane_dv  [NUM_LANES];

   assign port_wck[0] = wr_clk_p0;
   assign port_wck[1] = wr_clk_p1;
   assign port_rck[0] = rd_clk_p0;
   assign port_rck[1] = rd_clk_p1;
   assign port_din[0] = wr_data_p0;
   assign port_din[1] = wr_data_p1;

   for (genvar p = 0; p < NUM_LANES; p++) begin : g_port
      assign port_w[p] = side_ctl_t'(act_ctl[p*CTL_PER_PORT+3 +: 3]);
      assign port_r[p] = side_ctl_t'(act_ctl[p*CTL_PER_PORT   +: 3]);
   end

   for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
      logic      wck, rck;
      side_ctl_t wc, rc;
      if (k == 0) begin : g_own
         assign wck = port_wck[0];
         assign rck = port_rck[0];
         assign wc  = port_w[0];
         assign rc  = port_r[0];
      end else begin : g_shared
         // Wide mode: this lane follows port 0 entirely.
         assign wck = mode_split ? port_wck[k] : port_wck[0];
         assign rck = mode_split ? port_rck[k] : port_rck[0];
         assign wc  = mode_split ? port_w[k]   : port_w[0];
         assign rc  = mode_split ? port_r[k]   : port_r[0];
      end

      dlf_lane #(.DEPTH(DEPTH), .LANE_W(LANE_W)) u_lane (
         .wclk(wck),
         .rclk(rck),
         .wc  (wc),
         .rc  (rc),
         .din (port_din[k]),
         .dout(lane_do[k]),
         .dval(lane_dv[k])
      );
   end

   assign rd_data_p0  = lane_do[0];
   assign rd_valid_p0 = lane_dv[0];
   assign rd_data_p1  = lane_do[1];
   assign rd_valid_p1 = lane_dv[1];

   a_r9_lanes_qualify_together: assert property (@(posedge rd_clk_p0) disable iff (mode_split)
      !mode_split |=> (rd_valid_p0 == rd_valid_p1))
      else $error("a_r9_lanes_qualify_together");

endmodule

// File: tb/sim_dualmode_line_fifo.sv
`timescale 1ns/1ps
module sim_dualmode_line_fifo;

   localparam int DEPTH = 8;
   localparam int W     = 16;

   logic clk_a = 1'b0;   // port 0, 200 MHz
   logic clk_b = 1'b0;   // port 1, unrelated period
   always #2.5 clk_a = ~clk_a;
   always #3.5 clk_b = ~clk_b;

   logic mode_split = 1'b1;
   logic pol        = 1'b0;
   bit   lw_en [2];
   bit   lw_ie [2];
   bit   lw_rs [2];
   bit   lr_en [2];
   bit   lr_oe [2];
   bit   lr_rs [2];
   logic [W-1:0] din0 = '0, din1 = '0;
   logic [W-1:0] dout0, dout1;
   logic         dval0, dval1;

   dualmode_line_fifo #(.DEPTH(DEPTH), .LANE_W(W)) u0 (
      .mode_split  (mode_split),
      .pol_low     (pol),
      .wr_clk_p0   (clk_a),
      .wr_rst_p0   (lw_rs[0] ^ pol),
      .wr_en_p0    (lw_en[0] ^ pol),
      .wr_in_en_p0 (lw_ie[0] ^ pol),
      .wr_data_p0  (din0),
      .rd_clk_p0   (clk_a),
      .rd_rst_p0   (lr_rs[0] ^ pol),
      .rd_en_p0    (lr_en[0] ^ pol),
      .rd_out_en_p0(lr_oe[0] ^ pol),
      .rd_data_p0  (dout0),
      .rd_valid_p0 (dval0),
      .wr_clk_p1   (clk_b),
      .wr_rst_p1   (lw_rs[1] ^ pol),
      .wr_en_p1    (lw_en[1] ^ pol),
      .wr_in_en_p1 (lw_ie[1] ^ pol),
      .wr_data_p1  (din1),
      .rd_clk_p1   (clk_b),
      .rd_rst_p1   (lr_rs[1] ^ pol),
      .rd_en_p1    (lr_en[1] ^ pol),
      .rd_out_en_p1(lr_oe[1] ^ pol),
      .rd_data_p1  (dout1),
      .rd_valid_p1 (dval1)
   );

   int n_run = 0, n_fail = 0;

   // Reference state per lane, derived from the requirements.
   logic [W-1:0] mm [2][DEPTH];
   int           wp [2], rp [2];
   bit           wpd [2], rpd [2];
   logic [W-1:0] wq [2];
   bit           vq [2];

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_neg(int l);
      if (l == 1 && mode_split) @(negedge clk_b); else @(negedge clk_a);
   endtask

   task automatic wait_pos(int l);
      if (l == 1 && mode_split) @(posedge clk_b); else @(posedge clk_a);
   endtask

   task automatic mdl_w(int k, bit we, bit ie, bit rs, logic [W-1:0] d);
      if (we) begin
         if (rs || wpd[k]) begin wp[k] = 0; wpd[k] = 0; end
         else if (ie) begin mm[k][wp[k]] = d; wp[k] = (wp[k] + 1) % DEPTH; end
      end else if (rs) wpd[k] = 1;
   endtask

   task automatic mdl_r(int k, bit re, bit oe, bit rs);
      if (re) begin
         if (rs || rpd[k]) begin rp[k] = 0; rpd[k] = 0; end
         else begin wq[k] = mm[k][rp[k]]; rp[k] = (rp[k] + 1) % DEPTH; end
      end else if (rs) rpd[k] = 1;
      vq[k] = oe;
   endtask

   task automatic wcyc(int l, bit we, bit ie, bit rs, logic [W-1:0] d0, logic [W-1:0] d1);
      wait_neg(l);
      lw_en[l] = we; lw_ie[l] = ie; lw_rs[l] = rs;
      din0 = d0; din1 = d1;
      wait_pos(l);
      #1;
      lw_en[l] = 0; lw_ie[l] = 0; lw_rs[l] = 0;
      if (mode_split) mdl_w(l, we, ie, rs, (l == 0) ? d0 : d1);
      else begin
         mdl_w(0, we, ie, rs, d0);
         mdl_w(1, we, ie, rs, d1);
      end
   endtask

   task automatic cmp_lane(int k, string tag);
      logic [W:0] act, exp;
      act = (k == 0) ? {dval0, dout0} : {dval1, dout1};
      exp = {vq[k], vq[k] ? wq[k] : {W{1'b0}}};
      chk(act == exp, tag, 32'(act), 32'(exp));
   endtask

   task automatic rcyc(int l, bit re, bit oe, bit rs, string tag);
      wait_neg(l);
      lr_en[l] = re; lr_oe[l] = oe; lr_rs[l] = rs;
      wait_pos(l);
      #1;
      lr_en[l] = 0; lr_oe[l] = 0; lr_rs[l] = 0;
      if (mode_split) begin
         mdl_r(l, re, oe, rs);
         cmp_lane(l, tag);
      end else begin
         mdl_r(0, re, oe, rs);
         mdl_r(1, re, oe, rs);
         cmp_lane(0, tag);
         cmp_lane(1, tag);
      end
   endtask

   function automatic logic [W-1:0] pat(int l, int pass, int i);
      return W'(l * 'h1000 + pass * 'h0100 + i * 'h0011 + 'h0005);
   endfunction

   initial begin
      for (int k = 0; k < 2; k++) begin
         wp[k] = 0; rp[k] = 0; wpd[k] = 0; rpd[k] = 0; wq[k] = '0; vq[k] = 0;
         for (int a = 0; a < DEPTH; a++) mm[k][a] = '0;
      end
      repeat (3) @(posedge clk_a);

      // Reset state, split mode, active-high controls (R5, R8)
      for (int l = 0; l < 2; l++) begin
         wcyc(l, 1, 0, 1, '0, '0);
         rcyc(l, 1, 0, 1, "R8 reset state");
      end

      // Lane 0 fill with a gated and a disabled attempt mixed in (R2), then drain (R3)
      for (int i = 0; i < DEPTH; i++) begin
         if (i == 3) begin
            wcyc(0, 1, 0, 0, 16'hDEAD, '0);
            wcyc(0, 0, 1, 0, 16'hBEEF, '0);
         end
         wcyc(0, 1, 1, 0, pat(0, 0, i), '0);
      end
      for (int i = 0; i < DEPTH; i++) rcyc(0, 1, 1, 0, "R2 R3 in-order drain");

      // Wrap of both pointers (R4)
      for (int i = 0; i < 3; i++) wcyc(0, 1, 1, 0, pat(0, 1, i), '0);
      for (int i = 0; i < 3; i++) rcyc(0, 1, 1, 0, "R4 wrap overwrite");

      // Output enable off while reading, then on while idle (R8)
      for (int i = 0; i < 2; i++) wcyc(0, 1, 1, 0, pat(0, 2, i), '0);
      rcyc(0, 1, 0, 0, "R8 hidden read");
      rcyc(0, 0, 1, 0, "R8 shown hold");
      rcyc(0, 0, 0, 0, "R3 idle no load");

      // Reset on an enabled cycle replaces the access (R5)
      wcyc(0, 1, 1, 1, 16'hCAFE, '0);
      for (int i = 0; i < 4; i++) wcyc(0, 1, 1, 0, pat(0, 3, i), '0);
      rcyc(0, 1, 1, 1, "R5 read reset no load");
      for (int i = 0; i < 4; i++) rcyc(0, 1, 1, 0, "R5 from address 0");

      // Pending resets (R6)
      wcyc(0, 0, 0, 1, 16'h1111, '0);
      wcyc(0, 0, 1, 0, 16'h2222, '0);
      wcyc(0, 1, 1, 0, 16'hF00D, '0);
      wcyc(0, 1, 1, 0, pat(0, 4, 0), '0);
      rcyc(0, 0, 1, 1, "R6 read reset held");
      rcyc(0, 0, 0, 0, "R6 still held");
      rcyc(0, 1, 1, 0, "R6 held reset executes");
      rcyc(0, 1, 1, 0, "R6 first word after reset");

      // Lone read reset re-reads from the start (R7)
      rcyc(0, 1, 1, 1, "R7 read reset");
      for (int i = 0; i < 4; i++) rcyc(0, 1, 1, 0, "R7 re-read");

      // Lane 1 on its own clock leaves lane 0 untouched (R10)
      wcyc(1, 1, 0, 1, '0, '0);
      for (int i = 0; i < DEPTH; i++) wcyc(1, 1, 1, 0, '0, pat(1, 0, i));
      rcyc(1, 1, 0, 1, "R10 lane 1 read reset");
      for (int i = 0; i < DEPTH; i++) rcyc(1, 1, 1, 0, "R10 lane 1 drain");
      rcyc(0, 0, 1, 0, "R10 lane 0 output unchanged");
      rcyc(0, 1, 1, 0, "R10 lane 0 pointer unchanged");

      // Active-low controls (R1)
      pol = 1'b1;
      for (int l = 0; l < 2; l++) begin
         wcyc(l, 1, 0, 1, '0, '0);
         rcyc(l, 1, 0, 1, "R1 reset active low");
         for (int i = 0; i < 5; i++)
            wcyc(l, 1, 1, 0, pat(l, 5, i), pat(l, 5, i));
         wcyc(l, 0, 0, 0, 16'h7777, 16'h7777);
         for (int i = 0; i < 5; i++) rcyc(l, 1, 1, 0, "R1 data active low");
         rcyc(l, 0, 0, 0, "R1 high level inactive");
      end

      // Wide mode, port-1 controls held active as noise (R9)
      mode_split = 1'b0;
      repeat (2) @(posedge clk_a);
      lw_en[1] = 1; lw_ie[1] = 1; lw_rs[1] = 1;
      lr_en[1] = 1; lr_oe[1] = 1; lr_rs[1] = 1;
      wcyc(0, 1, 0, 1, '0, '0);
      rcyc(0, 1, 0, 1, "R9 wide reset");
      for (int i = 0; i < DEPTH + 2; i++) wcyc(0, 1, 1, 0, pat(0, 6, i), pat(1, 6, i));
      for (int i = 0; i < DEPTH; i++) rcyc(0, 1, 1, 0, "R9 wide data");
      rcyc(0, 0, 0, 0, "R9 wide qualifier off");

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #200000;
      n_run++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule